// File: doc/BRIEF.md
# Converter Status and Interrupt Register Block

This block is the register-side companion of a three-channel measurement front end. The three channels measure current, voltage and temperature. It holds one data register per channel and a 16-bit status word. It receives result strobes with raw signed values from the converters, level and pulse indications from a result FIFO, and the running value of the current-channel accumulator. A processor reaches it through a simple read/write register bus.

A raw result outside the 24-bit signed range is clamped to the nearest full-scale code, and that channel's error flag is set. A data register only accepts a new result once software has acknowledged the previous one, by reading and so clearing the ready flags. The exception is while the processor is powered down: in that state the registers always track the newest result. Only the lower byte of the status word can interrupt. It is masked bit by bit, and the masked bits are ORed onto one interrupt line.

The register map uses word addresses:

| Address | Register |
|---|---|
| 0 | status, read-only |
| 1 | interrupt mask |
| 2 | mode; bit 0 enables the current channel |
| 3 | configuration; bit 0 enables the FIFO, bit 1 enables the accumulator comparator |
| 4 | current data |
| 5 | voltage data |
| 6 | temperature data |
| 7 | accumulator threshold |

Top module: `adc_status_regs`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: `irq` is high exactly when some bit of status[7:0] is set together with the same bit of the mask register (address 1); status bits 8 to 15 never affect `irq`.
- R3: A strobe on `resStb[0]`, `resStb[1]` or `resStb[2]` sets status bit 0, 1 or 2 (current, voltage, temperature) on the next edge, and a strobe in the same cycle as a clearing read leaves that bit set.
- R4: With mode bit 0 set, a read of address 4 clears status bits 0 to 2; with mode bit 0 clear, a read of address 5 or 6 clears them instead; no other read clears them.
- R5: A channel's data register loads the clamped result on its strobe only while that channel's ready bit is clear, and otherwise keeps its value; data reads return the 24-bit value sign-extended to 32 bits.
- R6: While `corePd` is high, every strobe loads its data register regardless of the ready bit.
- R7: A raw result above 2^23-1 is stored as 0x7FFFFF and one below -2^23 as 0x800000; either sets status bit 12, 13 or 14 (current, voltage, temperature), and a stored in-range result for that channel clears it.
- R8: Status bit 15 sets on `calDone` and clears on any write to the mode register (address 2).
- R9: While configuration bit 0 is set, `fifoOvf` sets status bit 9 and `fifoFull` sets status bit 7; both stay set until the configuration register is written, and both read 0 while configuration bit 0 is clear.
- R10: Status bit 8 equals `fifoEmpty` while configuration bit 0 is set, and reads 0 otherwise.
- R11: While configuration bit 1 is set, status bit 6 sets when the absolute value of `accVal` exceeds the threshold register (address 7), unsigned; it stays set until a configuration write and reads 0 while bit 1 is clear.
- R12: Status bits 3, 4, 5, 10 and 11 and bits 16 to 31 of a status read are 0, and writes to address 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (drives side effects) |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busRe is high |
| irq | output | 1 | Masked interrupt to the processor |
| resStb | input | 3 | Result strobes: bit 0 current, 1 voltage, 2 temperature |
| rawCur | input | 28 | Signed raw current result |
| rawVolt | input | 28 | Signed raw voltage result |
| rawTemp | input | 28 | Signed raw temperature result |
| corePd | input | 1 | Processor powered down |
| calDone | input | 1 | Calibration cycle finished (pulse) |
| fifoEmpty | input | 1 | FIFO empty level |
| fifoFull | input | 1 | FIFO full level |
| fifoOvf | input | 1 | FIFO overflow event (pulse) |
| accVal | input | 32 | Signed current-channel accumulator value |

## Verification
A wrong ready bit shows in two places on the edge after the fault. One is the status read. The other is the next result on that channel, which is either dropped or overwrites unread data, so it appears on the following data read. A clamp or error-flag fault shows on the first out-of-range result, and a sticky FIFO or comparator flag that is wrong shows on the next status read. Because the interrupt is compared with a reference model on every clock, a mask or OR fault shows within one cycle of the offending status bit changing.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;

  localparam int NCH = 3;

  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_MASK = 3'd1,
    A_MODE = 3'd2,
    A_CFG  = 3'd3,
    A_DCUR = 3'd4,
    A_DVOL = 3'd5,
    A_DTMP = 3'd6,
    A_THR  = 3'd7
  } regAddr_e;

  // status bit positions that software decodes
  localparam int B_ACC   = 6;
  localparam int B_FULL  = 7;
  localparam int B_EMPTY = 8;
  localparam int B_OVF   = 9;
  localparam int B_ERR0  = 12;
  localparam int B_CAL   = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic           wrMask;
    logic           wrMode;
    logic           wrCfg;
    logic           wrThr;
    logic           rdyClr;
    logic [NCH-1:0] load;
    logic [NCH-1:0] rdySet;
    logic           calSet;
  } ctrlStb_t;

endpackage

// File: rtl/adc_stat_ctrl.sv
module adc_stat_ctrl
  import adc_stat_pkg::*;
(
  input  logic           busWe,
  input  logic           busRe,
  input  logic [2:0]     busAddr,
  input  logic [NCH-1:0] resStb,
  input  logic [NCH-1:0] rdyNow,
  input  logic           curEn,
  input  logic           corePd,
  input  logic           calDone,
  output ctrlStb_t       stb
);

  logic wrHit;
  logic clrByCur;
  logic clrByOther;

  always_comb begin
    wrHit      = busWe;
    clrByCur   = busRe && (busAddr == A_DCUR) && curEn;
    clrByOther = busRe && ((busAddr == A_DVOL) || (busAddr == A_DTMP)) && !curEn;

    stb.wrMask = wrHit && (busAddr == A_MASK);
    stb.wrMode = wrHit && (busAddr == A_MODE);
    stb.wrCfg  = wrHit && (busAddr == A_CFG);
    stb.wrThr  = wrHit && (busAddr == A_THR);
    stb.rdyClr = clrByCur || clrByOther;
    stb.rdySet = resStb;
    stb.calSet = calDone;
  end

  // a result passes only into an acknowledged register, unless powered down
  for (genvar c = 0; c < NCH; c++) begin : g_gate
    always_comb stb.load[c] = resStb[c] && (!rdyNow[c] || corePd);
  end

endmodule

// File: rtl/adc_stat_dpath.sv
module adc_stat_dpath
  import adc_stat_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int RAW_W = 28,
  parameter int ACC_W = 32,
  parameter int BUS_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStb_t                  stb,
  input  logic [2:0]                busAddr,
  input  logic                      busRe,
  input  logic [BUS_W-1:0]          busWdata,
  input  logic [NCH-1:0][RAW_W-1:0] rawBus,
  input  logic                      fifoEmpty,
  input  logic                      fifoFull,
  input  logic                      fifoOvf,
  input  logic [ACC_W-1:0]          accVal,
  output logic [BUS_W-1:0]          busRdata,
  output logic                      irq,
  output logic [15:0]               statWord,
  output logic [NCH-1:0]            rdyBits,
  output logic [7:0]                maskReg,
  output logic [7:0]                modeReg,
  output logic [7:0]                cfgReg,
  output logic [NCH-1:0][RES_W-1:0] datBus
);

  localparam int EXT_W = BUS_W - RES_W;
  localparam int PAD_W = RAW_W - RES_W + 1;
  localparam logic signed [RAW_W-1:0] MAXV = {{PAD_W{1'b0}}, {(RES_W-1){1'b1}}};
  localparam logic signed [RAW_W-1:0] MINV = {{PAD_W{1'b1}}, {(RES_W-1){1'b0}}};

  logic [NCH-1:0]  errBits;
  logic            calFlag;
  logic            fullFlag;
  logic            ovfFlag;
  logic            accFlag;
  logic [ACC_W-1:0] thrReg;
  logic            fifoOn;
  logic            accOn;
  logic [ACC_W:0]  accExt;
  logic [ACC_W:0]  accAbs;
  logic            accOver;

  assign fifoOn = cfgReg[0];
  assign accOn  = cfgReg[1];

  // per-channel clamp, data and error flag
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [RAW_W-1:0] rawS;
    logic                    isOver;
    logic                    isUnder;
    logic [RES_W-1:0]        clamped;

    assign rawS    = rawBus[c];
    assign isOver  = rawS > MAXV;
    assign isUnder = rawS < MINV;

    always_comb begin
      if (isOver)       clamped = MAXV[RES_W-1:0];
      else if (isUnder) clamped = MINV[RES_W-1:0];
      else              clamped = rawS[RES_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        datBus[c]  <= '0;
        errBits[c] <= 1'b0;
      end else if (stb.load[c]) begin
        datBus[c]  <= clamped;
        errBits[c] <= isOver || isUnder;
      end
    end

    // a new result wins over a clearing read in the same cycle
    always_ff @(posedge clk) begin
      if (!rstN)               rdyBits[c] <= 1'b0;
      else if (stb.rdySet[c])  rdyBits[c] <= 1'b1;
      else if (stb.rdyClr)     rdyBits[c] <= 1'b0;
    end
  end

  // software-visible control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      modeReg <= '0;
      cfgReg  <= '0;
      thrReg  <= '0;
    end else begin
      if (stb.wrMask) maskReg <= busWdata[7:0];
      if (stb.wrMode) modeReg <= busWdata[7:0];
      if (stb.wrCfg)  cfgReg  <= busWdata[7:0];
      if (stb.wrThr)  thrReg  <= busWdata[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           calFlag <= 1'b0;
    else if (stb.wrMode) calFlag <= 1'b0;
    else if (stb.calSet) calFlag <= 1'b1;
  end

  // FIFO sticky flags: reconfiguration or disable clears
  always_ff @(posedge clk) begin
    if (!rstN || stb.wrCfg || !fifoOn) begin
      fullFlag <= 1'b0;
      ovfFlag  <= 1'b0;
    end else begin
      if (fifoFull) fullFlag <= 1'b1;
      if (fifoOvf)  ovfFlag  <= 1'b1;
    end
  end

  // accumulator magnitude comparator
  assign accExt  = {accVal[ACC_W-1], accVal};
  assign accAbs  = accExt[ACC_W] ? (~accExt + 1'b1) : accExt;
  assign accOver = accAbs > {1'b0, thrReg};

  always_ff @(posedge clk) begin
    if (!rstN || stb.wrCfg || !accOn) accFlag <= 1'b0;
    else if (accOver)                 accFlag <= 1'b1;
  end

  always_comb begin
    statWord             = '0;
    statWord[NCH-1:0]    = rdyBits;
    statWord[B_ACC]      = accFlag;
    statWord[B_FULL]     = fullFlag;
    statWord[B_EMPTY]    = fifoOn && fifoEmpty;
    statWord[B_OVF]      = ovfFlag;
    statWord[B_ERR0+2:B_ERR0] = errBits;
    statWord[B_CAL]      = calFlag;
  end

  assign irq = |(statWord[7:0] & maskReg);

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      unique case (busAddr)
        A_STAT: busRdata = {{(BUS_W-16){1'b0}}, statWord};
        A_MASK: busRdata = {{(BUS_W-8){1'b0}}, maskReg};
        A_MODE: busRdata = {{(BUS_W-8){1'b0}}, modeReg};
        A_CFG:  busRdata = {{(BUS_W-8){1'b0}}, cfgReg};
        A_DCUR: busRdata = {{EXT_W{datBus[0][RES_W-1]}}, datBus[0]};
        A_DVOL: busRdata = {{EXT_W{datBus[1][RES_W-1]}}, datBus[1]};
        A_DTMP: busRdata = {{EXT_W{datBus[2][RES_W-1]}}, datBus[2]};
        A_THR:  busRdata = {{(BUS_W-ACC_W){1'b0}}, thrReg};
        default: busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/adc_status_regs.sv
module adc_status_regs
  import adc_stat_pkg::*;
#(
  parameter int RES_W = 24,
  parameter int RAW_W = 28,
  parameter int ACC_W = 32,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic             busRe,
  input  logic [2:0]       busAddr,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             irq,
  input  logic [2:0]       resStb,
  input  logic [RAW_W-1:0] rawCur,
  input  logic [RAW_W-1:0] rawVolt,
  input  logic [RAW_W-1:0] rawTemp,
  input  logic             corePd,
  input  logic             calDone,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic             fifoOvf,
  input  logic [ACC_W-1:0] accVal
);

  ctrlStb_t                  stb;
  logic [NCH-1:0]            rdyBits;
  logic [15:0]               statWord;
  logic [7:0]                maskReg;
  logic [7:0]                modeReg;
  logic [7:0]                cfgReg;
  logic [NCH-1:0][RES_W-1:0] datBus;
  logic [NCH-1:0][RAW_W-1:0] rawBus;

  assign rawBus = {rawTemp, rawVolt, rawCur};

  adc_stat_ctrl u_ctrl (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .resStb  (resStb),
    .rdyNow  (rdyBits),
    .curEn   (modeReg[0]),
    .corePd  (corePd),
    .calDone (calDone),
    .stb     (stb)
  );

  adc_stat_dpath #(
    .RES_W (RES_W),
    .RAW_W (RAW_W),
    .ACC_W (ACC_W),
    .BUS_W (BUS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busAddr   (busAddr),
    .busRe     (busRe),
    .busWdata  (busWdata),
    .rawBus    (rawBus),
    .fifoEmpty (fifoEmpty),
    .fifoFull  (fifoFull),
    .fifoOvf   (fifoOvf),
    .accVal    (accVal),
    .busRdata  (busRdata),
    .irq       (irq),
    .statWord  (statWord),
    .rdyBits   (rdyBits),
    .maskReg   (maskReg),
    .modeReg   (modeReg),
    .cfgReg    (cfgReg),
    .datBus    (datBus)
  );

endmodule

// File: rtl/adc_stat_chk.sv
module adc_stat_chk #(
  parameter int RES_W = 24,
  parameter int BUS_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWe,
  input logic                  busRe,
  input logic [2:0]            busAddr,
  input logic [BUS_W-1:0]      busRdata,
  input logic                  irq,
  input logic [2:0]            resStb,
  input logic                  corePd,
  input logic [15:0]           statWord,
  input logic [7:0]            maskReg,
  input logic [7:0]            cfgReg,
  input logic [2:0][RES_W-1:0] datBus
);

  // R2
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == 8'h00) |-> !irq);

  // R3
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    resStb[0] |=> statWord[0]);

  // R5
  hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resStb[1] && statWord[1] && !corePd) |=> $stable(datBus[1]));

  // R8
  cal_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 3'd2) |=> !statWord[15]);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWord[9] && !(busWe && busAddr == 3'd3)) |=> statWord[9]);

  // R10
  fifo_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg[0] |-> (!statWord[7] && !statWord[8] && !statWord[9]));

  // R12
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == 3'd0) |-> (busRdata[5:3] == 3'b000 &&
      busRdata[11:10] == 2'b00 && busRdata[BUS_W-1:16] == '0));

endmodule

bind adc_status_regs adc_stat_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busWe    (busWe),
  .busRe    (busRe),
  .busAddr  (busAddr),
  .busRdata (busRdata),
  .irq      (irq),
  .resStb   (resStb),
  .corePd   (corePd),
  .statWord (statWord),
  .maskReg  (maskReg),
  .cfgReg   (cfgReg),
  .datBus   (datBus)
);

// File: tb/adc_status_regs_test.sv
module adc_status_regs_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWe, busRe;
  logic [2:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        irq;
  logic [2:0]  resStb;
  logic [27:0] rawCur, rawVolt, rawTemp;
  logic        corePd, calDone, fifoEmpty, fifoFull, fifoOvf;
  logic [31:0] accVal;

  int    nCmp = 0;
  int    nBad = 0;
  string curTag = "R1";
  bit    doneFlag = 1'b0;

  always #2 clk = ~clk;

  adc_status_regs uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .resStb(resStb),
    .rawCur(rawCur), .rawVolt(rawVolt), .rawTemp(rawTemp), .corePd(corePd),
    .calDone(calDone), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .fifoOvf(fifoOvf), .accVal(accVal)
  );

  // behavioural reference model
  int     mDat [3];
  bit     mRdy [3];
  bit     mErr [3];
  bit     mCal, mFull, mOvf, mAcc;
  bit [7:0]  mMask, mMode, mCfg;
  bit [31:0] mThr;
  bit     mClr;
  bit     mLd [3];
  longint mR, mA;

  function automatic longint rawOf(int c);
    if (c == 0) return longint'($signed(rawCur));
    if (c == 1) return longint'($signed(rawVolt));
    return longint'($signed(rawTemp));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin mDat[c] = 0; mRdy[c] = 0; mErr[c] = 0; end
      mCal = 0; mFull = 0; mOvf = 0; mAcc = 0;
      mMask = 0; mMode = 0; mCfg = 0; mThr = 0;
    end else begin
      mClr = busRe && ((busAddr == 3'd4 && mMode[0]) ||
                       ((busAddr == 3'd5 || busAddr == 3'd6) && !mMode[0]));
      for (int c = 0; c < 3; c++) mLd[c] = resStb[c] && (!mRdy[c] || corePd);
      for (int c = 0; c < 3; c++) begin
        if (mLd[c]) begin
          mR = rawOf(c);
          if (mR > 64'sd8388607)       begin mDat[c] = 8388607;  mErr[c] = 1; end
          else if (mR < -64'sd8388608) begin mDat[c] = -8388608; mErr[c] = 1; end
          else                         begin mDat[c] = int'(mR); mErr[c] = 0; end
        end
        mRdy[c] = resStb[c] ? 1'b1 : (mRdy[c] && !mClr);
      end
      if (busWe && busAddr == 3'd2) mCal = 0;
      else if (calDone)             mCal = 1;
      if ((busWe && busAddr == 3'd3) || !mCfg[0]) begin mFull = 0; mOvf = 0; end
      else begin
        if (fifoFull) mFull = 1;
        if (fifoOvf)  mOvf  = 1;
      end
      mA = longint'($signed(accVal));
      if (mA < 0) mA = -mA;
      if ((busWe && busAddr == 3'd3) || !mCfg[1]) mAcc = 0;
      else if (mA > longint'(mThr))               mAcc = 1;
      if (busWe) begin
        case (busAddr)
          3'd1: mMask = busWdata[7:0];
          3'd2: mMode = busWdata[7:0];
          3'd3: mCfg  = busWdata[7:0];
          3'd7: mThr  = busWdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] expStat();
    logic [31:0] s = '0;
    s[0] = mRdy[0]; s[1] = mRdy[1]; s[2] = mRdy[2];
    s[6] = mAcc; s[7] = mFull; s[8] = mCfg[0] && fifoEmpty; s[9] = mOvf;
    s[12] = mErr[0]; s[13] = mErr[1]; s[14] = mErr[2]; s[15] = mCal;
    return s;
  endfunction

  function automatic logic [31:0] expRead(logic [2:0] a);
    case (a)
      3'd0: return expStat();
      3'd1: return {24'd0, mMask};
      3'd2: return {24'd0, mMode};
      3'd3: return {24'd0, mCfg};
      3'd4: return mDat[0];
      3'd5: return mDat[1];
      3'd6: return mDat[2];
      default: return mThr;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare this cycle, then advance to the next negedge and drop pulses
  task automatic go();
    logic [7:0] se;
    #1;
    se = expStat()[7:0];
    check("R2", {31'd0, irq}, {31'd0, |(se & mMask)});
    if (busRe) check(curTag, busRdata, expRead(busAddr));
    @(negedge clk);
    busWe = 0; busRe = 0; resStb = 0; calDone = 0; fifoOvf = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    busWe = 1; busAddr = a; busWdata = d; go();
  endtask

  task automatic rd(logic [2:0] a);
    busRe = 1; busAddr = a; go();
  endtask

  task automatic res(logic [2:0] s, logic [27:0] c, logic [27:0] v, logic [27:0] t);
    resStb = s; rawCur = c; rawVolt = v; rawTemp = t; go();
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rstN = 0; busWe = 0; busRe = 0; busAddr = 0; busWdata = 0; resStb = 0;
    rawCur = 0; rawVolt = 0; rawTemp = 0; corePd = 0; calDone = 0;
    fifoEmpty = 0; fifoFull = 0; fifoOvf = 0; accVal = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset contents
    curTag = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a));

    // R3: strobe sets ready; R4 needs current channel enabled
    curTag = "R3";
    wr(3'd2, 32'h1);
    res(3'b001, 28'd100, 28'd0, 28'd0);
    rd(3'd0);
    resStb = 3'b001; rawCur = 28'd7; busRe = 1; busAddr = 3'd4; go();  // R3 collision
    rd(3'd0);

    // R4: clearing reads
    curTag = "R4";
    rd(3'd4); rd(3'd0);
    res(3'b110, 28'd0, 28'd55, 28'd66);
    rd(3'd5); rd(3'd0);  // current enabled: no clear
    wr(3'd2, 32'h0);
    rd(3'd6); rd(3'd0);  // current disabled: clears

    // R5: data held while ready is set
    curTag = "R5";
    res(3'b010, 28'd0, 28'd1000, 28'd0);
    res(3'b010, 28'd0, 28'd2000, 28'd0);
    rd(3'd5);
    res(3'b010, 28'h0FFFFFF & 28'(-12), 28'h0FFFFFF & 28'(-12), 28'd0);
    rd(3'd5);

    // R6: power-down bypass
    curTag = "R6";
    corePd = 1;
    res(3'b111, 28'd11, 28'd22, 28'd33);
    res(3'b111, 28'd44, 28'd55, 28'd66);
    corePd = 0;
    rd(3'd4); rd(3'd6);

    // R7: clamping and error flags
    curTag = "R7";
    wr(3'd2, 32'h1); rd(3'd4);
    res(3'b001, 28'h1000000, 28'd0, 28'd0);
    rd(3'd0); rd(3'd4);
    res(3'b100, 28'd0, 28'd0, 28'h8000000);
    rd(3'd0); wr(3'd2, 32'h0); rd(3'd6); rd(3'd0);
    res(3'b110, 28'd0, 28'h9000000, 28'd3);
    rd(3'd0); rd(3'd5); rd(3'd0);
    wr(3'd2, 32'h1); rd(3'd4);
    res(3'b001, 28'd5, 28'd0, 28'd0);
    rd(3'd0);

    // R2: masking
    curTag = "R2";
    wr(3'd1, 32'h01); rd(3'd0);
    wr(3'd1, 32'h02); rd(3'd0);
    wr(3'd1, 32'hFF); rd(3'd4); rd(3'd0);

    // R8: calibration flag
    curTag = "R8";
    calDone = 1; go();
    rd(3'd0);
    wr(3'd2, 32'h1); rd(3'd0);

    // R9/R10: FIFO flags
    curTag = "R9";
    fifoOvf = 1; fifoFull = 1; go(); fifoFull = 0;
    rd(3'd0);
    wr(3'd3, 32'h1);
    fifoOvf = 1; go();
    fifoFull = 1; go(); fifoFull = 0;
    rd(3'd0); rd(3'd0);
    curTag = "R10";
    fifoEmpty = 1; rd(3'd0);
    curTag = "R9";
    wr(3'd3, 32'h1); rd(3'd0);
    fifoOvf = 1; go();
    wr(3'd3, 32'h0); rd(3'd0);
    curTag = "R10";
    rd(3'd0); fifoEmpty = 0;

    // R11: accumulator threshold
    curTag = "R11";
    wr(3'd7, 32'd1000);
    accVal = -32'sd1500; go(); rd(3'd0);
    wr(3'd3, 32'h2);
    accVal = -32'sd1000; go(); rd(3'd0);
    accVal = -32'sd1001; go(); rd(3'd0);
    accVal = 32'd0; go(); rd(3'd0);
    wr(3'd3, 32'h2); rd(3'd0);
    accVal = 32'h80000000; go(); rd(3'd0);
    wr(3'd3, 32'h0); rd(3'd0); accVal = 0;

    // R12: status is read-only
    curTag = "R12";
    wr(3'd0, 32'hFFFFFFFF); rd(3'd0); rd(3'd1); rd(3'd2); rd(3'd3);

    go(); go();
    doneFlag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule